// File: doc/BRIEF.md
# Memory Error Status and Capture Register

This block logs errors reported by the memory subsystem. Each error arrives as a one-cycle event that carries an error-type index, a severity class, a physical address, a 9-bit data syndrome, a 4-bit tag syndrome and the privilege level of the processor at that moment. Every error type has a sticky status bit. A multiple-error flag records a repeated serious error of the same type. A single shared capture holds an address, both syndromes and the privilege level. It is guarded by a severity-ranked lock.

Software reads the state through a small word-addressed register port and clears it by writing ones. A read never changes anything. The capture stays locked to the event it holds until software clears that event's status bit. A disrupting-interrupt output is asserted while the enable input is high and any status bit marked as disrupting is set. Software must therefore clear those bits before it re-enables interrupts.

A bus transaction of 64 bytes can report an ECC error in any of its four beats. Only the first such error is logged. Later ones in the same transaction are dropped without a trace.

Top module: `mel_top`

## Requirements
- R1: After reset, the status word, the address word, the syndrome word and `irq_o` all read 0.
- R2: An accepted event sets the status bit at position `evt_type_i` of word 0 (address 0). That bit stays set until it is cleared by a write, and bits of different types accumulate side by side.
- R3: Writing to word 0 clears every status bit whose write-data bit is 1. Write-data bit 30 clears the privilege bit and bit 31 clears the multiple-error flag. Writes to word 1 (address) and word 2 (syndromes: data syndrome in bits 8:0, tag syndrome in bits 19:16) have no effect. Reads clear nothing.
- R4: The multiple-error flag (word 0 bit 31) is set when an accepted event of class 1 (software-correctable) or class 2/3 (uncorrectable) finds its own status bit already set. A repeated class 0 (hardware-corrected) event never sets it.
- R5: An event with `evt_burst_i`=1 is ignored when an earlier burst event has already been accepted since the last `txn_start_i` pulse. An ignored event changes no status bit, no flag and no capture. A burst event in the same cycle as `txn_start_i` opens the new transaction and is accepted.
- R6: An accepted event is captured while the capture is unlocked: its address goes to word 1, its syndromes to word 2, and `evt_priv_i` to word 0 bit 30.
- R7: Severity rank orders captures: uncorrectable (class 2 or 3) above software-correctable (1) above hardware-corrected (0). A higher-rank event overwrites a locked capture. An event of equal or lower rank does not.
- R8: The capture unlocks once the status bit of the event it holds is cleared, even while other status bits remain set. The captured values stay readable until the next capture.
- R9: `irq_o` is high exactly when `irq_en_i` is high and a status bit that is set in parameter `DISRUPT_MASK` is set. The default mask makes types 4 to 15 disrupting.
- R10: If a clear write and an event for the same status bit or flag occur in the same cycle, the bit or flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One-cycle error event strobe |
| evt_type_i | input | TYPE_W | Error-type index |
| evt_class_i | input | 2 | Severity: 0 hw-corrected, 1 sw-correctable, 2/3 uncorrectable |
| evt_addr_i | input | ADDR_W | Physical address of the error |
| evt_dsyn_i | input | DSYN_W | Data ECC syndrome |
| evt_tsyn_i | input | TSYN_W | Tag ECC syndrome |
| evt_priv_i | input | 1 | Privilege level at detection |
| evt_burst_i | input | 1 | Event is an ECC error from a multi-beat bus transaction |
| txn_start_i | input | 1 | Start of a new bus transaction |
| reg_addr_i | input | 2 | Register word select |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data (ones clear) |
| reg_rdata_o | output | 32 | Read data of the selected word |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Disrupting interrupt request |

## Verification
A software clear and a new error event can land in the same cycle. Two such collisions matter. In the first, a clear of a status bit or of the multiple-error flag meets an event that sets the same bit. The bench issues both in one cycle and expects the bit to survive. In the second, a clear of the bit that holds the capture meets a rival event. Lock release is judged separately: one cycle after the clear, a lower-rank event must be captured, while other status bits that are still set must not hold the lock.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int REG_W = 32;
  localparam logic [1:0] WORD_STATUS = 2'd0;
  localparam logic [1:0] WORD_ADDR   = 2'd1;
  localparam logic [1:0] WORD_SYN    = 2'd2;
  localparam int PRIV_BIT  = 30;
  localparam int MULTI_BIT = 31;
  localparam int TSYN_LSB  = 16;

  typedef enum logic [1:0] {
    RANK_HWC = 2'd0,
    RANK_SWC = 2'd1,
    RANK_UNC = 2'd2
  } rank_e;

  function automatic logic [1:0] cls_rank(logic [1:0] cls);
    return (cls == 2'd3) ? 2'(RANK_UNC) : cls;
  endfunction
endpackage

// File: rtl/mel_burst_filter.sv
module mel_burst_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_valid_i,
  input  logic evt_burst_i,
  input  logic txn_start_i,
  output logic accept_o
);
  logic seen_q;
  logic burst_evt;

  assign burst_evt = evt_valid_i & evt_burst_i;
  assign accept_o  = evt_valid_i & ~(evt_burst_i & seen_q & ~txn_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (txn_start_i) seen_q <= burst_evt;
    else if (burst_evt)   seen_q <= 1'b1;
  end
endmodule

// File: rtl/mel_status.sv
module mel_status #(
  parameter int N_TYPES = 16,
  localparam int TYPE_W = $clog2(N_TYPES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [1:0]         rank_i,
  input  logic [N_TYPES-1:0] clr_i,
  input  logic               clr_multi_i,
  output logic [N_TYPES-1:0] status_o,
  output logic               multi_o
);
  logic [N_TYPES-1:0] status_q, set_vec;
  logic multi_q, multi_set, type_ok;

  assign type_ok = 32'(type_i) < N_TYPES;

  always_comb begin
    set_vec = '0;
    if (acc_i && type_ok) set_vec[type_i] = 1'b1;
  end

  assign multi_set = acc_i && type_ok && (rank_i != mel_pkg::RANK_HWC) && status_q[type_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      multi_q  <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_vec;
      multi_q  <= (multi_q & ~clr_multi_i) | multi_set;
    end
  end

  assign status_o = status_q;
  assign multi_o  = multi_q;

  a_r4_multi_severity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(multi_q) |-> $past(acc_i && rank_i != mel_pkg::RANK_HWC));

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && type_ok) |=> status_q[$past(type_i)]);
endmodule

// File: rtl/mel_lock.sv
module mel_lock #(
  parameter int N_TYPES = 16,
  localparam int TYPE_W = $clog2(N_TYPES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [1:0]         rank_i,
  input  logic [N_TYPES-1:0] status_i,
  output logic               cap_en_o,
  output logic               locked_o,
  output logic [1:0]         held_rank_o
);
  logic              held_valid_q;
  logic [TYPE_W-1:0] held_type_q;
  logic [1:0]        held_rank_q;

  // lock lives only as long as the held event's status bit
  assign locked_o    = held_valid_q & status_i[held_type_q];
  assign cap_en_o    = acc_i & (~locked_o | (rank_i > held_rank_q));
  assign held_rank_o = held_rank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_valid_q <= 1'b0;
      held_type_q  <= '0;
      held_rank_q  <= '0;
    end else if (cap_en_o) begin
      held_valid_q <= 1'b1;
      held_type_q  <= type_i;
      held_rank_q  <= rank_i;
    end
  end
endmodule

// File: rtl/mel_top.sv
module mel_top #(
  parameter int N_TYPES = 16,
  parameter int ADDR_W  = 32,
  parameter int DSYN_W  = 9,
  parameter int TSYN_W  = 4,
  parameter logic [N_TYPES-1:0] DISRUPT_MASK = 16'hFFF0,
  localparam int TYPE_W = $clog2(N_TYPES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [TYPE_W-1:0] evt_type_i,
  input  logic [1:0]        evt_class_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [DSYN_W-1:0] evt_dsyn_i,
  input  logic [TSYN_W-1:0] evt_tsyn_i,
  input  logic              evt_priv_i,
  input  logic              evt_burst_i,
  input  logic              txn_start_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o
);
  import mel_pkg::*;

  logic               acc, cap_en, locked, wr_status;
  logic [1:0]         rank, held_rank;
  logic [N_TYPES-1:0] status, clr_vec;
  logic               multi;
  logic [ADDR_W-1:0]  addr_q;
  logic [DSYN_W-1:0]  dsyn_q;
  logic [TSYN_W-1:0]  tsyn_q;
  logic               priv_q;
  logic               unused_wdata;

  assign rank      = cls_rank(evt_class_i);
  assign wr_status = reg_we_i && (reg_addr_i == WORD_STATUS);
  assign clr_vec   = wr_status ? reg_wdata_i[N_TYPES-1:0] : '0;
  assign unused_wdata = ^reg_wdata_i[PRIV_BIT-1:N_TYPES];

  mel_burst_filter u_filter (
    .clk_i, .rst_ni, .evt_valid_i, .evt_burst_i, .txn_start_i,
    .accept_o(acc)
  );

  mel_status #(.N_TYPES(N_TYPES)) u_status (
    .clk_i, .rst_ni, .acc_i(acc), .type_i(evt_type_i), .rank_i(rank),
    .clr_i(clr_vec), .clr_multi_i(wr_status & reg_wdata_i[MULTI_BIT]),
    .status_o(status), .multi_o(multi)
  );

  mel_lock #(.N_TYPES(N_TYPES)) u_lock (
    .clk_i, .rst_ni, .acc_i(acc), .type_i(evt_type_i), .rank_i(rank),
    .status_i(status), .cap_en_o(cap_en), .locked_o(locked),
    .held_rank_o(held_rank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dsyn_q <= '0;
      tsyn_q <= '0;
      priv_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= evt_addr_i;
      dsyn_q <= evt_dsyn_i;
      tsyn_q <= evt_tsyn_i;
      priv_q <= evt_priv_i;
    end else if (wr_status && reg_wdata_i[PRIV_BIT]) begin
      priv_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      WORD_STATUS: begin
        reg_rdata_o[N_TYPES-1:0] = status;
        reg_rdata_o[PRIV_BIT]    = priv_q;
        reg_rdata_o[MULTI_BIT]   = multi;
      end
      WORD_ADDR: reg_rdata_o[ADDR_W-1:0] = addr_q;
      WORD_SYN: begin
        reg_rdata_o[DSYN_W-1:0]           = dsyn_q;
        reg_rdata_o[TSYN_LSB +: TSYN_W]   = tsyn_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_en_i & |(status & DISRUPT_MASK);

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(status) & ~status) |-> $past(wr_status));

  a_r5_drop_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !acc && !reg_we_i) |=> ($stable(status) && $stable(multi) && $stable(addr_q)));

  a_r7_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !(acc && rank > held_rank)) |=> ($stable(addr_q) && $stable(dsyn_q) && $stable(tsyn_q)));

  a_r9_irq_needs_disrupt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && (status & DISRUPT_MASK) != '0));
endmodule

// File: tb/test_mel_top.sv
module test_mel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 0, evt_priv = 0, evt_burst = 0, txn_start = 0;
  logic [3:0]  evt_type = 0;
  logic [1:0]  evt_class = 0;
  logic [31:0] evt_addr = 0;
  logic [8:0]  evt_dsyn = 0;
  logic [3:0]  evt_tsyn = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq_en = 0, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mel_top i_mel_top (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_type_i(evt_type),
    .evt_class_i(evt_class), .evt_addr_i(evt_addr), .evt_dsyn_i(evt_dsyn),
    .evt_tsyn_i(evt_tsyn), .evt_priv_i(evt_priv), .evt_burst_i(evt_burst),
    .txn_start_i(txn_start), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_en_i(irq_en), .irq_o(irq)
  );

  localparam logic [1:0] HWC = 2'd0, SWC = 2'd1, UNC = 2'd2;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_word(string req, logic [1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // drive one event (and optionally a write) for one cycle; state is readable afterwards
  task automatic cycle(logic ev, logic [3:0] t, logic [1:0] c, logic [31:0] a,
                       logic [8:0] ds, logic [3:0] ts, logic pv, logic bu, logic st,
                       logic we, logic [1:0] wa, logic [31:0] wd);
    evt_valid = ev; evt_type = t; evt_class = c; evt_addr = a; evt_dsyn = ds;
    evt_tsyn = ts; evt_priv = pv; evt_burst = bu; txn_start = st;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    @(negedge clk);
    evt_valid = 0; evt_burst = 0; txn_start = 0; reg_we = 0;
  endtask

  task automatic send(logic [3:0] t, logic [1:0] c, logic [31:0] a,
                      logic [8:0] ds = 0, logic [3:0] ts = 0, logic pv = 0,
                      logic bu = 0, logic st = 0);
    cycle(1, t, c, a, ds, ts, pv, bu, st, 0, 0, 0);
  endtask

  task automatic wr(logic [1:0] wa, logic [31:0] wd);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, wa, wd);
  endtask

  task automatic t_reset;
    chk_word("R1 status", 0, 0);
    chk_word("R1 addr", 1, 0);
    chk_word("R1 syndromes", 2, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_sticky;
    send(3, HWC, 32'h10);
    send(5, HWC, 32'h20);
    send(3, HWC, 32'h30);
    chk_word("R2 accumulate", 0, 32'h28);   // R4: repeated hwc, no multi
    chk_word("R3 read does not clear", 0, 32'h28);
    wr(0, 32'h08);
    chk_word("R3 w1c single bit", 0, 32'h20);
    wr(0, 32'hFFFF_FFFF);
    chk_word("R3 w1c all", 0, 0);
  endtask

  task automatic t_multi;
    send(7, SWC, 32'h40);
    chk_word("R4 first swc no multi", 0, 32'h80);
    send(7, SWC, 32'h44);
    chk_word("R4 repeated swc", 0, 32'h8000_0080);
    wr(0, 32'hFFFF_FFFF);
    send(9, UNC, 32'h50);
    send(9, 2'd3, 32'h54);
    chk_word("R4 repeated unc", 0, 32'h8000_0200);
    wr(0, 32'h8000_0000);
    chk_word("R3 clear multi only", 0, 32'h200);
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_capture;
    send(1, HWC, 32'hA0, 9'h011, 4'h1, 1);
    chk_word("R6 capture addr", 1, 32'hA0);
    chk_word("R6 capture syndromes", 2, 32'h0001_0011);
    chk_word("R6 capture priv", 0, 32'h4000_0002);
    send(2, HWC, 32'hB0, 9'h0FF, 4'hF, 0);
    chk_word("R7 equal rank no overwrite", 1, 32'hA0);
    send(8, SWC, 32'hC0, 9'h1AB, 4'hC, 0);
    chk_word("R7 higher rank overwrites addr", 1, 32'hC0);
    chk_word("R7 higher rank overwrites syn", 2, 32'h000C_01AB);
    send(3, HWC, 32'hD0, 9'h001, 4'h2, 1);
    chk_word("R7 lower rank no overwrite", 1, 32'hC0);
    send(10, UNC, 32'hE0, 9'h155, 4'h5, 1);
    chk_word("R7 unc overwrites", 1, 32'hE0);
    chk_word("R6 status and priv", 0, 32'h4000_050E);
    wr(0, 32'h2);
    send(4, SWC, 32'hF0, 9'h002, 4'h3, 0);
    chk_word("R8 clearing other bit keeps lock", 1, 32'hE0);
    wr(0, 32'h400);
    chk_word("R8 value stays after unlock", 1, 32'hE0);
    chk_word("R8 syn stays after unlock", 2, 32'h0005_0155);
    send(5, HWC, 32'h55, 9'h0A2, 4'h3, 0);
    chk_word("R8 unlocked capture with bits set", 1, 32'h55);
    chk_word("R8 status", 0, 32'h13C);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    chk_word("R3 addr write ignored", 1, 32'h55);
    chk_word("R3 syn write ignored", 2, 32'h0003_00A2);
  endtask

  task automatic t_burst;
    send(6, UNC, 32'h100, 0, 0, 0, 1, 1);
    chk_word("R5 first burst error logged", 1, 32'h100);
    send(6, UNC, 32'h104, 0, 0, 0, 1, 0);
    send(11, UNC, 32'h108, 0, 0, 0, 1, 0);
    chk_word("R5 later beats ignored", 0, 32'h40);
    chk_word("R5 later beats no capture", 1, 32'h100);
    send(6, UNC, 32'h110, 0, 0, 0, 0, 0);
    chk_word("R5 non-burst still counts", 0, 32'h8000_0040);
    send(12, HWC, 32'h120, 0, 0, 0, 1, 1);
    chk_word("R5 new transaction logged", 0, 32'h8000_1040);
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    irq_en = 1;
    send(1, HWC, 32'h200);
    chk("R9 non-disrupting bit", {31'd0, irq}, 0);
    send(6, SWC, 32'h204);
    chk("R9 disrupting bit", {31'd0, irq}, 1);
    irq_en = 0; #1;
    chk("R9 enable low", {31'd0, irq}, 0);
    irq_en = 1; #1;
    chk("R9 enable restored", {31'd0, irq}, 1);
    wr(0, 32'h40);
    chk("R9 cleared", {31'd0, irq}, 0);
    irq_en = 0;
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins;
    send(2, HWC, 32'h300);
    cycle(1, 2, HWC, 32'h304, 0, 0, 0, 0, 0, 1, 0, 32'h4);
    chk_word("R10 status set beats clear", 0, 32'h4);
    send(9, SWC, 32'h310);
    send(9, SWC, 32'h314);
    cycle(1, 9, SWC, 32'h318, 0, 0, 0, 0, 0, 1, 0, 32'h8000_0200);
    chk_word("R10 multi and status survive clear", 0, 32'h8000_0204);
    wr(0, 32'hFFFF_FFFF);
    chk_word("R3 final clear", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sticky;
    t_multi;
    t_capture;
    t_burst;
    t_irq;
    t_set_wins;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule